// File: doc/BRIEF.md
# Six-Pin Bidirectional Port Controller

This block is a six-bit general-purpose I/O port that sits on a small register bus. It has a synchronous write side with an address, a data byte and two single-bit modify strobes, and a combinational read side. Internally it holds an output latch, a direction mask, a per-pin pull-up enable mask, an analog-select mask and a global pull-up disable flag. For each pad it drives an output enable, an output value and a pull-up enable. The raw pad levels come back through a two-stage synchronizer.

A read of the data register returns the synchronized pin levels, not the latch. Pins marked analog read as zero. The input-only pin 3 also reads zero while the external-reset function is enabled. A bit-set or bit-clear on the data register reads the pin levels as the data register would return them, changes one bit, and writes all six bits back into the latch. As a result, an output pin that is held against its latch value can corrupt the latch. Pin 3 is never driven and never pulled up. A pull-up is active only when its enable bit is set, its pin is an input, and the global disable flag is clear.

Register selects: 0 = pin data / output latch, 1 = direction, 2 = pull-up enables, 3 = analog mask, 4 = control (bit 0 = global pull-up disable). Selects 5 to 7 read 0 and ignore writes.

Top module: `gpio6_port`

## Requirements
- R1: A read of select 0 returns {2'b00, pins}, where pins are the pad levels after two rising edges of synchronization. A pad change shows on the read after the second edge and not after the first.
- R2: A direction bit of 0 sets pad_oe for that pin. A direction bit of 1 clears it. pad_do always equals the output latch. A direction write shows on pad_oe after one edge.
- R3: Pin 3 is input-only. Select 1 always reads bit 3 as 1. Select 2 always reads bit 3 as 0. pad_oe[3] and pad_pu[3] are always 0.
- R4: A write to select 0 loads wr_data[5:0] into the output latch only. The value read from select 0 still comes from the pads.
- R5: A set strobe (bset_en) or clear strobe (bclr_en) with bit_idx on select 0 takes the current select-0 read value, sets or clears bit bit_idx, and stores the whole result in the latch. On the other selects the strobe modifies the stored register. A bit_idx of 6 or more has no effect.
- R6: A pin whose analog-mask bit is 1 reads 0 on select 0, and its pad_oe still follows its direction bit.
- R7: While mclr_en is 1, bit 3 of the select-0 read is 0.
- R8: pad_pu[i] is 1 only when pull-up enable bit i is 1 and pin i is an input. An output pin never has its pull-up on.
- R9: When the global pull-up disable (select 4, bit 0) is 1, all pad_pu bits are 0.
- R10: After reset the registers read as follows: direction 0x3F, latch 0x00, pull-up enables 0x37, analog mask 0x00, control 0x01. Reads of selects 5 to 7 return 0. Bits 7:6 of every read are 0.
- R11: When strobes come in the same cycle, wr_en takes priority over bset_en, and bset_en over bclr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register select for reads and writes |
| wr_en | input | 1 | Write wr_data to the selected register |
| wr_data | input | 8 | Write data |
| bset_en | input | 1 | Set bit bit_idx of the selected register |
| bclr_en | input | 1 | Clear bit bit_idx of the selected register |
| bit_idx | input | 3 | Bit position for set and clear |
| rd_data | output | 8 | Combinational read data for reg_sel |
| mclr_en | input | 1 | External-reset function enable for pin 3 |
| pin_in | input | 6 | Raw pad levels |
| pad_oe | output | 6 | Per-pin output enable |
| pad_do | output | 6 | Per-pin output value |
| pad_pu | output | 6 | Per-pin weak pull-up enable |

## Verification
Register state changes on the rising edge that captures a strobe. From that edge, pad_oe, pad_do, pad_pu and rd_data show the new state, so the bench drives inputs on a falling edge and checks at the next falling edge. A change at the pads takes two rising edges to reach the select-0 read. The bench checks once after the first edge to see the old value, and again after the second edge. Before every read-modify-write it waits three cycles so that the synchronizer has settled. rd_data and the mclr_en and analog masking are combinational in reg_sel, so those checks take place one time step after the select changes.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
    localparam int PORT_W   = 6;
    localparam int BUS_W    = 8;
    localparam int SEL_W    = 3;
    localparam int IDX_W    = 3;
    localparam int SYNC_N   = 2;
    localparam int IN_ONLY  = 3;

    localparam logic [PORT_W-1:0] IN_ONLY_MASK = PORT_W'(1) << IN_ONLY;

    localparam logic [PORT_W-1:0] RST_DIR   = '1;
    localparam logic [PORT_W-1:0] RST_LATCH = '0;
    localparam logic [PORT_W-1:0] RST_PULL  = ~IN_ONLY_MASK;
    localparam logic [PORT_W-1:0] RST_ANA   = '0;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_PULL = 3'd2,
        SEL_ANA  = 3'd3,
        SEL_CTRL = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] pull;
        logic [PORT_W-1:0] ana;
        logic              pu_off;
    } port_state_t;
endpackage

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
    parameter int W      = gpio6_pkg::PORT_W,
    parameter int STAGES = gpio6_pkg::SYNC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

    // R1
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(raw_i) && $stable(stage_q[0]) |=> $stable(sync_o));
endmodule

// File: rtl/gpio6_view.sv
module gpio6_view
    import gpio6_pkg::*;
(
    input  port_state_t        st,
    input  logic [PORT_W-1:0]  pins_sync,
    input  logic               mclr_en,
    output logic [PORT_W-1:0]  pin_view,
    output logic [PORT_W-1:0]  pad_oe,
    output logic [PORT_W-1:0]  pad_do,
    output logic [PORT_W-1:0]  pad_pu
);
    logic [PORT_W-1:0] rst_pin_mask;
    logic [PORT_W-1:0] pu_gate;

    always_comb begin
        rst_pin_mask = mclr_en ? IN_ONLY_MASK : '0;
        pin_view     = pins_sync & ~st.ana & ~rst_pin_mask;
        pad_oe       = ~st.dir & ~IN_ONLY_MASK;
        pad_do       = st.latch;
        pu_gate      = {PORT_W{~st.pu_off}};
        pad_pu       = st.pull & st.dir & ~IN_ONLY_MASK & pu_gate;
    end

    // R7
    always_comb begin
        rst_pin_read_chk: assert (!mclr_en || !pin_view[IN_ONLY]);
    end
endmodule

// File: rtl/gpio6_regs.sv
module gpio6_regs
    import gpio6_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic               wr_en,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               bset_en,
    input  logic               bclr_en,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic [PORT_W-1:0]  pin_view,
    output port_state_t        st_q
);
    port_state_t       st_d;
    logic [PORT_W-1:0] cur_port;
    logic [PORT_W-1:0] bit_mask;
    logic [PORT_W-1:0] mod_port;
    logic [PORT_W-1:0] new_port;
    logic              cur_ctrl;
    logic              new_ctrl;
    logic              do_write;

    always_comb begin
        bit_mask = (int'(bit_idx) < PORT_W) ? (PORT_W'(1) << bit_idx) : '0;
        case (reg_sel)
            SEL_DATA: cur_port = pin_view;
            SEL_DIR:  cur_port = st_q.dir;
            SEL_PULL: cur_port = st_q.pull;
            SEL_ANA:  cur_port = st_q.ana;
            default:  cur_port = '0;
        endcase
        cur_ctrl = st_q.pu_off;

        if (bset_en)      mod_port = cur_port | bit_mask;
        else              mod_port = cur_port & ~bit_mask;

        if (bset_en && bit_idx == '0)      new_ctrl = 1'b1;
        else if (bclr_en && bit_idx == '0) new_ctrl = 1'b0;
        else                               new_ctrl = cur_ctrl;

        do_write = wr_en || bset_en || bclr_en;
        new_port = wr_en ? wr_data[PORT_W-1:0] : mod_port;
        if (wr_en) new_ctrl = wr_data[0];

        st_d = st_q;
        if (do_write) begin
            case (reg_sel)
                SEL_DATA: st_d.latch  = new_port;
                SEL_DIR:  st_d.dir    = new_port | IN_ONLY_MASK;
                SEL_PULL: st_d.pull   = new_port & ~IN_ONLY_MASK;
                SEL_ANA:  st_d.ana    = new_port;
                SEL_CTRL: st_d.pu_off = new_ctrl;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch  <= RST_LATCH;
            st_q.dir    <= RST_DIR;
            st_q.pull   <= RST_PULL;
            st_q.ana    <= RST_ANA;
            st_q.pu_off <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    in_only_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dir[IN_ONLY] && !st_q.pull[IN_ONLY]);

    // R4
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_sel == SEL_DATA |=> st_q.latch == $past(wr_data[PORT_W-1:0]));

    // R5
    rmw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && bset_en && reg_sel == SEL_DATA && bit_idx < 3'd6
        |=> st_q.latch == ($past(pin_view) | (PORT_W'(1) << $past(bit_idx))));

    // R11
    set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en && bset_en && bclr_en && reg_sel == SEL_ANA && bit_idx < 3'd6
        |=> st_q.ana[$past(bit_idx)]);
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio6_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic               wr_en,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               bset_en,
    input  logic               bclr_en,
    input  logic [IDX_W-1:0]   bit_idx,
    output logic [BUS_W-1:0]   rd_data,
    input  logic               mclr_en,
    input  logic [PORT_W-1:0]  pin_in,
    output logic [PORT_W-1:0]  pad_oe,
    output logic [PORT_W-1:0]  pad_do,
    output logic [PORT_W-1:0]  pad_pu
);
    localparam int PAD_BITS = BUS_W - PORT_W;

    port_state_t       st;
    logic [PORT_W-1:0] pins_sync;
    logic [PORT_W-1:0] pin_view;

    gpio6_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (pins_sync)
    );

    gpio6_view u_view (
        .st        (st),
        .pins_sync (pins_sync),
        .mclr_en   (mclr_en),
        .pin_view  (pin_view),
        .pad_oe    (pad_oe),
        .pad_do    (pad_do),
        .pad_pu    (pad_pu)
    );

    gpio6_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .bset_en  (bset_en),
        .bclr_en  (bclr_en),
        .bit_idx  (bit_idx),
        .pin_view (pin_view),
        .st_q     (st)
    );

    always_comb begin
        case (reg_sel)
            SEL_DATA: rd_data = {{PAD_BITS{1'b0}}, pin_view};
            SEL_DIR:  rd_data = {{PAD_BITS{1'b0}}, st.dir};
            SEL_PULL: rd_data = {{PAD_BITS{1'b0}}, st.pull};
            SEL_ANA:  rd_data = {{PAD_BITS{1'b0}}, st.ana};
            SEL_CTRL: rd_data = {{(BUS_W-1){1'b0}}, st.pu_off};
            default:  rd_data = '0;
        endcase
    end

    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_sel == SEL_DIR
        |=> pad_oe == (~$past(wr_data[PORT_W-1:0]) & ~IN_ONLY_MASK));

    // R8
    pull_vs_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R9
    pull_global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && reg_sel == SEL_CTRL && wr_data[0] |=> pad_pu == '0);

    // R10
    rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BUS_W-1:PORT_W] == '0);
endmodule

// File: tb/gpio6_port_tb.sv
module gpio6_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_sel = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bset_en = 1'b0;
    logic       bclr_en = 1'b0;
    logic [2:0] bit_idx = '0;
    logic [7:0] rd_data;
    logic       mclr_en = 1'b0;
    logic [5:0] pin_in;
    logic [5:0] pad_oe, pad_do, pad_pu;
    logic [5:0] ext_en = '0;
    logic [5:0] ext_val = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio6_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .bset_en(bset_en), .bclr_en(bclr_en),
        .bit_idx(bit_idx), .rd_data(rd_data), .mclr_en(mclr_en),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
    );

    // Pad model: external driver wins, then own driver, then weak pull-up, else floats low
    always_comb begin
        for (int i = 0; i < 6; i++) begin
            if (ext_en[i])      pin_in[i] = ext_val[i];
            else if (pad_oe[i]) pin_in[i] = pad_do[i];
            else if (pad_pu[i]) pin_in[i] = 1'b1;
            else                pin_in[i] = 1'b0;
        end
    end

    // {select, write data, expected read of same select}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {3'd1, 8'hFF, 8'h3F},
        {3'd1, 8'h00, 8'h08},
        {3'd1, 8'hC5, 8'h0D},
        {3'd2, 8'hFF, 8'h37},
        {3'd2, 8'h0A, 8'h02},
        {3'd3, 8'h3C, 8'h3C},
        {3'd3, 8'h00, 8'h00},
        {3'd4, 8'hFE, 8'h00},
        {3'd4, 8'h01, 8'h01},
        {3'd5, 8'hAA, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus(input logic w, input logic s, input logic c,
                       input logic [2:0] sel, input logic [7:0] d, input logic [2:0] idx);
        @(negedge clk);
        reg_sel = sel; wr_en = w; bset_en = s; bclr_en = c; wr_data = d; bit_idx = idx;
        @(negedge clk);
        wr_en = 0; bset_en = 0; bclr_en = 0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        bus(1, 0, 0, sel, d, 3'd0);
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=hung exp=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);

        // R10 reset values
        rd(3'd1, v); check("R10 dir", v, 8'h3F);
        rd(3'd2, v); check("R10 pull", v, 8'h37);
        rd(3'd3, v); check("R10 ana", v, 8'h00);
        rd(3'd4, v); check("R10 ctrl", v, 8'h01);
        rd(3'd6, v); check("R10 unused", v, 8'h00);
        check("R10 latch", {2'b00, pad_do}, 8'h00);
        check("R10 pu", {2'b00, pad_pu}, 8'h00);

        // Table walk: R2 R3 R8 R9 R10 write/read-back rules
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][18:16], VEC[k][15:8]);
            rd(VEC[k][18:16], v);
            check($sformatf("R3/R10 vec%0d", k), v, VEC[k][7:0]);
        end

        // R8 pull-up gating by direction
        wr(3'd4, 8'h00); wr(3'd2, 8'h37); wr(3'd1, 8'h3F);
        check("R8 all inputs", {2'b00, pad_pu}, 8'h37);
        wr(3'd1, 8'h3C);
        check("R8 outputs off", {2'b00, pad_pu}, 8'h34);
        check("R2 oe", {2'b00, pad_oe}, 8'h03);
        // R9 global disable
        wr(3'd4, 8'h01);
        check("R9 global off", {2'b00, pad_pu}, 8'h00);

        // R1 two-edge synchronizer latency
        wr(3'd4, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'h3F);
        wait_cyc(3);
        ext_en = 6'h3F; ext_val = 6'h25;
        reg_sel = 3'd0;
        @(negedge clk); rd(3'd0, v); check("R1 one edge", v, 8'h00);
        @(negedge clk); rd(3'd0, v); check("R1 two edges", v, 8'h25);
        ext_val = 6'h08; wait_cyc(3);
        // R7 reset-shared pin
        mclr_en = 1'b1; rd(3'd0, v); check("R7 forced", v, 8'h00);
        mclr_en = 1'b0; rd(3'd0, v); check("R7 released", v, 8'h08);

        // R6 analog masking
        ext_val = 6'h3F; wait_cyc(3);
        wr(3'd3, 8'h05);
        rd(3'd0, v); check("R6 masked", v, 8'h3A);
        wr(3'd1, 8'h3E);
        check("R6 oe follows dir", {2'b00, pad_oe}, 8'h01);
        wr(3'd3, 8'h00); wr(3'd1, 8'h3F);

        // R4 data write touches latch only
        ext_val = 6'h00; wait_cyc(3);
        wr(3'd0, 8'hFF);
        check("R4 latch", {2'b00, pad_do}, 8'h3F);
        wait_cyc(3);
        rd(3'd0, v); check("R4 read is pins", v, 8'h00);

        // R2 drive latch to pads
        ext_en = 6'h00;
        wr(3'd1, 8'h30);
        check("R2 oe", {2'b00, pad_oe}, 8'h07);
        wait_cyc(3);
        rd(3'd0, v); check("R2 pins driven", v, 8'h07);

        // R5 read-modify-write corruption
        wr(3'd1, 8'h3C); wr(3'd0, 8'h03);
        ext_en = 6'h01; ext_val = 6'h00;
        wait_cyc(3);
        bus(0, 1, 0, 3'd0, 8'h00, 3'd4);
        check("R5 set corrupts", {2'b00, pad_do}, 8'h12);
        wait_cyc(3);
        bus(0, 0, 1, 3'd0, 8'h00, 3'd1);
        check("R5 clear", {2'b00, pad_do}, 8'h00);
        bus(0, 1, 0, 3'd2, 8'h00, 3'd7);
        rd(3'd2, v); check("R5 idx out of range", v, 8'h00);
        bus(0, 1, 0, 3'd2, 8'h00, 3'd5);
        rd(3'd2, v); check("R5 set pull", v, 8'h20);

        // R11 priority
        bus(1, 1, 0, 3'd0, 8'h2A, 3'd0);
        check("R11 write over set", {2'b00, pad_do}, 8'h2A);
        bus(0, 1, 1, 3'd3, 8'h00, 3'd2);
        rd(3'd3, v); check("R11 set over clear", v, 8'h04);

        // R3 input-only pin never driven or pulled
        ext_en = 6'h00;
        wr(3'd4, 8'h00); wr(3'd2, 8'hFF); wr(3'd1, 8'h00);
        check("R3 oe", {2'b00, pad_oe}, 8'h37);
        wr(3'd1, 8'hFF);
        check("R3 pu", {2'b00, pad_pu}, 8'h37);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule